// File: doc/BRIEF.md
# Core Soft Reset and FIFO Flush Sequencer

This block owns the reset-and-flush control register of a USB-style controller. Software writes request bits through a 32-bit register write port, and the block turns each request into a reset or flush strobe towards the rest of the core. Each request has its own fixed duration. While it runs, the request bit reads back as 1, and it drops to 0 by itself when the operation completes. Software polls the bit to learn that the work is done.

The operations are a full core reset, a reset of the bus-clock pipelines only, a reset of the frame number counter, a flush of the IN-token learning queue, a receive FIFO flush and a transmit FIFO flush. A 5-bit target field picks the transmit FIFO to flush. It can name the non-periodic FIFO, one periodic FIFO, or all of them at once. Two read-only bits report whether a DMA request is in progress and whether the bus master is idle.

The block also holds an interrupt status register and an interrupt mask register. These show how a full core reset treats them: the mask is cleared and the status is kept. A frame counter shows the effect of a frame counter reset on the next start-of-frame.

Top module: `softrst_flush_ctrl`

## Requirements
- R1: After the synchronous reset, `ctrl_o` bits 10:0 are 0, every reset and flush strobe is low, `intsts_o`, `intmsk_o`, `irq_o` and `frame_num_o` are 0.
- R2: A control write (`wr_addr`=0) with bit 4 set raises `ctrl_o[4]` and `rx_flush_o` from the cycle after the write, for exactly FLUSH_CYC (8) cycles, and then both clear by themselves. Bit 5 with `tx_flush_o` behaves the same way.
- R3: Control bits 10:6 hold the transmit target. Value n from 0 to 15 drives only `tx_flush_o[n]` during a transmit flush. Value 16 drives every bit. Values 17 to 31 drive no bit, but bit 5 still self-clears after FLUSH_CYC cycles.
- R4: While bit 5 is pending, writes to bits 10:6 are ignored and the read-back target and `tx_flush_o` stay unchanged. When no transmit flush is pending, a control write updates the target without starting a flush.
- R5: Writing 0 to a pending request bit does not clear it early, and writing 1 to it again does not restart its timer.
- R6: A control write with bit 0 set, when no core reset is pending, holds `ctrl_o[0]` and `core_rst_o` high for CORE_CYC (16) cycles. During that time `bus_rst_o`, `tknq_flush_o`, `rx_flush_o` and every `tx_flush_o` bit are also high.
- R7: A core reset clears `intmsk_o` when it starts and ignores mask writes while pending. It leaves `intsts_o` and the target field unchanged. It cancels pending requests on bits 1 to 5, ignores new requests while pending, and zeroes `frame_num_o`.
- R8: Bit 1 holds `bus_rst_o` and bit 1 high for BUS_CYC (4) cycles. Bit 3 holds `tknq_flush_o` and bit 3 high for TKNQ_CYC (4) cycles.
- R9: `frame_num_o` is the number the next start-of-frame will carry, and it advances by one on each `sof_i` pulse. Bit 2 forces it to 0 and holds it there for FRAME_CYC (2) cycles, ignoring `sof_i`, so the next start-of-frame carries 0.
- R10: `ctrl_o[30]` follows `dma_req_i` and `ctrl_o[31]` follows `bus_idle_i`, one cycle late. Writes to these bits have no effect.
- R11: Each `int_event_i` bit sets the matching `intsts_o` bit. A write to `wr_addr`=1 clears the status bits written as 1, and a set wins over a clear in the same cycle. A write to `wr_addr`=2 loads the mask. `irq_o` is the OR of status AND mask, one cycle late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 status clear, 2 mask, 3 unused |
| wr_data | input | 32 | Write data |
| dma_req_i | input | 1 | DMA request in progress |
| bus_idle_i | input | 1 | Bus master idle |
| int_event_i | input | 32 | Interrupt event pulses |
| sof_i | input | 1 | Start-of-frame sent |
| ctrl_o | output | 32 | Control register read-back |
| intsts_o | output | 32 | Interrupt status |
| intmsk_o | output | 32 | Interrupt mask |
| irq_o | output | 1 | Masked interrupt request |
| core_rst_o | output | 1 | Full core reset strobe |
| bus_rst_o | output | 1 | Bus-clock pipeline reset strobe |
| tknq_flush_o | output | 1 | Token queue flush strobe |
| rx_flush_o | output | 1 | Receive FIFO flush strobe |
| tx_flush_o | output | NUM_TXF | Per-FIFO transmit flush strobes |
| frame_num_o | output | FRAME_W | Number for the next start-of-frame |

## Verification
The hardest case to reach is a full core reset that lands while other requests are still pending. It must cancel them, keep the interrupt status and the target field, and block mask writes and new requests for its whole window. The stimulus starts a receive flush and then, in the very next cycle, requests the core reset. In the following cycles it writes the mask and a new transmit request while the reset is still running. The same exact-cycle approach covers rewrites of a pending bit and target writes during a transmit flush, both issued a known number of cycles into the window.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned NUM_OPS = 6;
  localparam int unsigned TGT_W   = 5;
  localparam int unsigned TGT_LSB = 6;
  localparam logic [TGT_W-1:0] TGT_ALL = 5'h10;

  localparam int OP_CORE  = 0;
  localparam int OP_BUS   = 1;
  localparam int OP_FRAME = 2;
  localparam int OP_TKNQ  = 3;
  localparam int OP_RX    = 4;
  localparam int OP_TX    = 5;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_ISTS = 2'd1,
    A_IMSK = 2'd2,
    A_NONE = 2'd3
  } addr_e;
endpackage

// File: rtl/sfc_op_timer.sv
module sfc_op_timer #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic cancel_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cancel_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/sfc_tx_target.sv
module sfc_tx_target
  import sfc_pkg::*;
#(
  parameter int unsigned NUM_TXF = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tgt_we_i,
  input  logic [TGT_W-1:0]   tgt_i,
  input  logic               load_i,
  output logic [TGT_W-1:0]   tgt_o,
  output logic [NUM_TXF-1:0] mask_o
);
  logic [TGT_W-1:0]   tgt_q;
  logic [NUM_TXF-1:0] mask_q;
  logic [NUM_TXF-1:0] sel;

  for (genvar i = 0; i < NUM_TXF; i++) begin : g_dec
    assign sel[i] = (tgt_i == TGT_W'(i)) || (tgt_i == TGT_ALL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q  <= '0;
      mask_q <= '0;
    end else begin
      if (tgt_we_i) tgt_q  <= tgt_i;
      if (load_i)   mask_q <= sel;
    end
  end

  assign tgt_o  = tgt_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/sfc_int_regs.sv
module sfc_int_regs #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] event_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_i,
  input  logic         msk_we_i,
  input  logic [W-1:0] msk_i,
  input  logic         msk_clear_i,
  input  logic         msk_lock_i,
  output logic [W-1:0] sts_o,
  output logic [W-1:0] msk_o,
  output logic         irq_o
);
  logic [W-1:0] sts_q, msk_q;
  logic         irq_q;
  logic [W-1:0] clr_m;

  assign clr_m = clr_we_i ? clr_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      msk_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr_m) | event_i;
      if (msk_clear_i)                 msk_q <= '0;
      else if (msk_we_i && !msk_lock_i) msk_q <= msk_i;
      irq_q <= |(sts_q & msk_q);
    end
  end

  assign sts_o = sts_q;
  assign msk_o = msk_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/softrst_flush_ctrl.sv
module softrst_flush_ctrl
  import sfc_pkg::*;
#(
  parameter int unsigned NUM_TXF   = 16,
  parameter int unsigned FRAME_W   = 11,
  parameter int unsigned CORE_CYC  = 16,
  parameter int unsigned BUS_CYC   = 4,
  parameter int unsigned FRAME_CYC = 2,
  parameter int unsigned TKNQ_CYC  = 4,
  parameter int unsigned FLUSH_CYC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [31:0]        wr_data,
  input  logic               dma_req_i,
  input  logic               bus_idle_i,
  input  logic [31:0]        int_event_i,
  input  logic               sof_i,
  output logic [31:0]        ctrl_o,
  output logic [31:0]        intsts_o,
  output logic [31:0]        intmsk_o,
  output logic               irq_o,
  output logic               core_rst_o,
  output logic               bus_rst_o,
  output logic               tknq_flush_o,
  output logic               rx_flush_o,
  output logic [NUM_TXF-1:0] tx_flush_o,
  output logic [FRAME_W-1:0] frame_num_o
);
  localparam int unsigned OP_CYC [NUM_OPS] =
    '{CORE_CYC, BUS_CYC, FRAME_CYC, TKNQ_CYC, FLUSH_CYC, FLUSH_CYC};
  localparam int unsigned PAD_W = DATA_W - 2 - TGT_LSB - TGT_W;

  logic               wr_ctrl;
  logic               core_start;
  logic [NUM_OPS-1:0] start, cancel, busy;
  logic [TGT_W-1:0]   tgt;
  logic [NUM_TXF-1:0] tx_mask;
  logic               dma_q, idle_q;
  logic [FRAME_W-1:0] frame_q;

  assign wr_ctrl    = wr_en && (wr_addr == A_CTRL);
  assign core_start = wr_ctrl && wr_data[OP_CORE] && !busy[OP_CORE];

  always_comb begin
    start[OP_CORE]  = core_start;
    cancel[OP_CORE] = 1'b0;
    for (int k = 1; k < NUM_OPS; k++) begin
      start[k]  = wr_ctrl && wr_data[k] && !busy[OP_CORE] && !wr_data[OP_CORE];
      cancel[k] = core_start;
    end
  end

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
    sfc_op_timer #(.CYCLES(OP_CYC[k])) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .start_i  (start[k]),
      .cancel_i (cancel[k]),
      .busy_o   (busy[k])
    );
  end

  sfc_tx_target #(.NUM_TXF(NUM_TXF)) u_tgt (
    .clk      (clk),
    .rst      (rst),
    .tgt_we_i (wr_ctrl && !busy[OP_TX]),
    .tgt_i    (wr_data[TGT_LSB +: TGT_W]),
    .load_i   (start[OP_TX]),
    .tgt_o    (tgt),
    .mask_o   (tx_mask)
  );

  sfc_int_regs #(.W(DATA_W)) u_int (
    .clk         (clk),
    .rst         (rst),
    .event_i     (int_event_i),
    .clr_we_i    (wr_en && (wr_addr == A_ISTS)),
    .clr_i       (wr_data),
    .msk_we_i    (wr_en && (wr_addr == A_IMSK)),
    .msk_i       (wr_data),
    .msk_clear_i (core_start),
    .msk_lock_i  (busy[OP_CORE]),
    .sts_o       (intsts_o),
    .msk_o       (intmsk_o),
    .irq_o       (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_q   <= 1'b0;
      idle_q  <= 1'b0;
      frame_q <= '0;
    end else begin
      dma_q  <= dma_req_i;
      idle_q <= bus_idle_i;
      if (start[OP_CORE] || busy[OP_CORE] || start[OP_FRAME] || busy[OP_FRAME])
        frame_q <= '0;
      else if (sof_i)
        frame_q <= frame_q + 1'b1;
    end
  end

  assign ctrl_o       = {idle_q, dma_q, {PAD_W{1'b0}}, tgt, busy};
  assign core_rst_o   = busy[OP_CORE];
  assign bus_rst_o    = busy[OP_CORE] | busy[OP_BUS];
  assign tknq_flush_o = busy[OP_CORE] | busy[OP_TKNQ];
  assign rx_flush_o   = busy[OP_CORE] | busy[OP_RX];
  assign tx_flush_o   = busy[OP_CORE] ? {NUM_TXF{1'b1}} :
                        (busy[OP_TX] ? tx_mask : {NUM_TXF{1'b0}});
  assign frame_num_o  = frame_q;
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
  parameter int unsigned NUM_TXF   = 16,
  parameter int unsigned FRAME_W   = 11,
  parameter int unsigned FLUSH_CYC = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [5:0]         req_bits,
  input logic [4:0]         tgt,
  input logic [1:0]         stat,
  input logic               dma_req_i,
  input logic               bus_idle_i,
  input logic               sof_i,
  input logic [31:0]        intsts_o,
  input logic [31:0]        intmsk_o,
  input logic               irq_o,
  input logic               core_rst_o,
  input logic               bus_rst_o,
  input logic               tknq_flush_o,
  input logic               rx_flush_o,
  input logic [NUM_TXF-1:0] tx_flush_o,
  input logic [FRAME_W-1:0] frame_num_o
);
  logic [15:0] rx_run;

  always_ff @(posedge clk) begin
    if (rst)              rx_run <= '0;
    else if (req_bits[4]) rx_run <= rx_run + 1'b1;
    else                  rx_run <= '0;
  end

  p_rx_window_r2: assert property (@(posedge clk) disable iff (rst)
    req_bits[4] |-> rx_run < 16'(FLUSH_CYC));

  p_rx_selfclear_r2: assert property (@(posedge clk) disable iff (rst)
    (req_bits[4] && rx_run == 16'(FLUSH_CYC - 1)) |=> !req_bits[4]);

  p_target_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (req_bits[5] && $past(req_bits[5])) |-> tgt == $past(tgt));

  p_core_strobes_r6: assert property (@(posedge clk) disable iff (rst)
    core_rst_o |-> (bus_rst_o && tknq_flush_o && rx_flush_o && (&tx_flush_o)));

  p_mask_zero_r7: assert property (@(posedge clk) disable iff (rst)
    core_rst_o |-> intmsk_o == '0);

  p_frame_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (req_bits[2] || core_rst_o) |-> frame_num_o == '0);

  p_frame_step_r9: assert property (@(posedge clk) disable iff (rst)
    (sof_i && !req_bits[2] && !core_rst_o) |=>
      (req_bits[2] || core_rst_o || frame_num_o == FRAME_W'($past(frame_num_o) + 1'b1)));

  p_status_mirror_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> stat == $past({bus_idle_i, dma_req_i}));

  p_irq_follow_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_o == $past(|(intsts_o & intmsk_o)));
endmodule

bind softrst_flush_ctrl sfc_checker #(
  .NUM_TXF   (NUM_TXF),
  .FRAME_W   (FRAME_W),
  .FLUSH_CYC (FLUSH_CYC)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_bits     (ctrl_o[5:0]),
  .tgt          (ctrl_o[10:6]),
  .stat         (ctrl_o[31:30]),
  .dma_req_i    (dma_req_i),
  .bus_idle_i   (bus_idle_i),
  .sof_i        (sof_i),
  .intsts_o     (intsts_o),
  .intmsk_o     (intmsk_o),
  .irq_o        (irq_o),
  .core_rst_o   (core_rst_o),
  .bus_rst_o    (bus_rst_o),
  .tknq_flush_o (tknq_flush_o),
  .rx_flush_o   (rx_flush_o),
  .tx_flush_o   (tx_flush_o),
  .frame_num_o  (frame_num_o)
);

// File: tb/softrst_flush_ctrl_test.sv
module softrst_flush_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        dma_req_i = 1'b0;
  logic        bus_idle_i = 1'b0;
  logic [31:0] int_event_i = '0;
  logic        sof_i = 1'b0;
  logic [31:0] ctrl_o, intsts_o, intmsk_o;
  logic        irq_o, core_rst_o, bus_rst_o, tknq_flush_o, rx_flush_o;
  logic [15:0] tx_flush_o;
  logic [10:0] frame_num_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // {target, expected tx_flush_o}
  localparam logic [20:0] TGT_VEC [6] = '{
    {5'd0,  16'h0001},
    {5'd5,  16'h0020},
    {5'd15, 16'h8000},
    {5'd16, 16'hFFFF},
    {5'd17, 16'h0000},
    {5'd31, 16'h0000}
  };

  softrst_flush_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dma_req_i(dma_req_i), .bus_idle_i(bus_idle_i), .int_event_i(int_event_i),
    .sof_i(sof_i), .ctrl_o(ctrl_o), .intsts_o(intsts_o), .intmsk_o(intmsk_o),
    .irq_o(irq_o), .core_rst_o(core_rst_o), .bus_rst_o(bus_rst_o),
    .tknq_flush_o(tknq_flush_o), .rx_flush_o(rx_flush_o),
    .tx_flush_o(tx_flush_o), .frame_num_o(frame_num_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // called at a negedge; returns at the negedge after the capturing edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic sof_pulse();
    sof_i = 1'b1;
    tick();
    sof_i = 1'b0;
  endtask

  function automatic logic [31:0] tg(input logic [4:0] t);
    return {21'b0, t, 6'b0};
  endfunction

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    tick();

    // R1 reset state
    chk("R1 ctrl", {21'b0, ctrl_o[10:0]}, 32'h0);
    chk("R1 strobes", {11'b0, core_rst_o, bus_rst_o, tknq_flush_o, rx_flush_o, irq_o, tx_flush_o},
        32'h0);
    chk("R1 int regs", intsts_o | intmsk_o, 32'h0);
    chk("R1 frame", {21'b0, frame_num_o}, 32'h0);

    // R3 target decode table walk (also R2 timing for bit 5)
    for (int i = 0; i < 6; i++) begin
      wr(2'd0, tg(TGT_VEC[i][20:16]) | 32'h20);
      chk("R3 tx mask", {16'b0, tx_flush_o}, {16'b0, TGT_VEC[i][15:0]});
      chk("R3 target read", {27'b0, ctrl_o[10:6]}, {27'b0, TGT_VEC[i][20:16]});
      repeat (7) tick();
      chk("R2 tx still pending", {31'b0, ctrl_o[5]}, 32'h1);
      tick();
      chk("R2 tx self-clear", {15'b0, ctrl_o[5], tx_flush_o}, 32'h0);
    end

    // R2 receive flush window length
    wr(2'd0, tg(5'd31) | 32'h10);
    n = 0;
    while (rx_flush_o && ctrl_o[4] && n < 40) begin n++; tick(); end
    chk("R2 rx window", n, 8);
    chk("R2 rx cleared", {30'b0, ctrl_o[4], rx_flush_o}, 32'h0);

    // R4 target locked during transmit flush
    wr(2'd0, tg(5'd3) | 32'h20);
    wr(2'd0, tg(5'd9));
    chk("R4 target kept", {27'b0, ctrl_o[10:6]}, 32'd3);
    chk("R4 mask kept", {16'b0, tx_flush_o}, 32'h0008);
    repeat (8) tick();
    chk("R4 flush done", {31'b0, ctrl_o[5]}, 32'h0);
    wr(2'd0, tg(5'd9));
    chk("R4 target idle write", {27'b0, ctrl_o[10:6]}, 32'd9);
    chk("R4 no flush from target write", {15'b0, ctrl_o[5], tx_flush_o}, 32'h0);

    // R5 rewrite of pending bit
    wr(2'd0, tg(5'd9) | 32'h10);
    wr(2'd0, tg(5'd9));
    chk("R5 zero write no clear", {31'b0, ctrl_o[4]}, 32'h1);
    wr(2'd0, tg(5'd9) | 32'h10);
    n = 0;
    while (ctrl_o[4] && n < 40) begin n++; tick(); end
    chk("R5 no restart", n, 6);

    // R8 bus reset and token queue flush
    wr(2'd0, tg(5'd9) | 32'h02);
    n = 0;
    while (bus_rst_o && ctrl_o[1] && n < 40) begin n++; tick(); end
    chk("R8 bus reset window", n, 4);
    wr(2'd0, tg(5'd9) | 32'h08);
    n = 0;
    while (tknq_flush_o && ctrl_o[3] && n < 40) begin n++; tick(); end
    chk("R8 token flush window", n, 4);

    // R9 frame counter
    for (int i = 0; i < 5; i++) sof_pulse();
    chk("R9 frame count", {21'b0, frame_num_o}, 32'd5);
    wr(2'd0, tg(5'd9) | 32'h04);
    chk("R9 frame zeroed", {21'b0, frame_num_o}, 32'd0);
    sof_pulse();
    chk("R9 sof ignored while pending", {20'b0, ctrl_o[2], frame_num_o}, 32'h800);
    tick();
    chk("R9 next sof carries zero", {20'b0, ctrl_o[2], frame_num_o}, 32'h0);
    sof_pulse();
    chk("R9 counting resumes", {21'b0, frame_num_o}, 32'd1);

    // R10 status mirror
    dma_req_i = 1'b1; bus_idle_i = 1'b0;
    tick();
    chk("R10 dma/idle 01", {30'b0, ctrl_o[31:30]}, 32'h1);
    wr(2'd0, 32'hC000_0000 | tg(5'd9));
    chk("R10 write ignored", {30'b0, ctrl_o[31:30]}, 32'h1);
    dma_req_i = 1'b0; bus_idle_i = 1'b1;
    tick();
    chk("R10 dma/idle 10", {30'b0, ctrl_o[31:30]}, 32'h2);

    // R11 interrupt status and mask
    wr(2'd2, 32'h0000_0011);
    chk("R11 mask load", intmsk_o, 32'h11);
    int_event_i = 32'h10; tick(); int_event_i = '0;
    chk("R11 status set", intsts_o, 32'h10);
    tick();
    chk("R11 irq rise", {31'b0, irq_o}, 32'h1);
    int_event_i = 32'h100; tick(); int_event_i = '0;
    wr(2'd1, 32'h10);
    chk("R11 w1c", intsts_o, 32'h100);
    tick();
    chk("R11 irq fall", {31'b0, irq_o}, 32'h0);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h100; int_event_i = 32'h100;
    tick();
    wr_en = 1'b0; wr_data = '0; int_event_i = '0;
    chk("R11 set wins", intsts_o, 32'h100);
    int_event_i = 32'h1; tick(); int_event_i = '0;
    tick();
    chk("R11 irq before core", {31'b0, irq_o}, 32'h1);

    // R6 / R7 core reset over a pending receive flush
    wr(2'd0, tg(5'd9) | 32'h10);
    wr(2'd0, tg(5'd9) | 32'h01);
    chk("R6 core strobes", {10'b0, ctrl_o[0], core_rst_o, bus_rst_o, tknq_flush_o, rx_flush_o,
        1'b0, tx_flush_o}, 32'h3E_FFFF);
    chk("R7 rx cancelled", {31'b0, ctrl_o[4]}, 32'h0);
    chk("R7 mask cleared", intmsk_o, 32'h0);
    chk("R7 status kept", intsts_o, 32'h101);
    chk("R7 frame zeroed", {21'b0, frame_num_o}, 32'h0);
    wr(2'd2, 32'hFF);
    wr(2'd0, tg(5'd9) | 32'h20);
    n = 0;
    while (core_rst_o && ctrl_o[0] && n < 40) begin n++; tick(); end
    chk("R6 core window", n, 14);
    chk("R7 request ignored", {26'b0, ctrl_o[5:0]}, 32'h0);
    chk("R7 mask write ignored", intmsk_o, 32'h0);
    chk("R7 status after", intsts_o, 32'h101);
    chk("R7 target kept", {27'b0, ctrl_o[10:6]}, 32'd9);
    chk("R6 strobes released", {12'b0, bus_rst_o, tknq_flush_o, rx_flush_o, irq_o, tx_flush_o},
        32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule